// File: doc/BRIEF.md
# Chunk-Granular Register Scoreboard

This block tracks pending register writes for a SIMD core whose architectural registers are 256 bits wide. It does not keep one busy flag per register. It keeps one busy flag for each 16-bit slice of every register, so each register has 16 flags. A narrow write, such as loading a 16-bit piece of a constant, then marks only the slices it touches. Later readers of the other slices of that register are not held back by a false dependency.

Next to each busy flag the block stores one more bit. That bit records whether the pending producer may hand its result over the bypass network. A full write leaves the bypass open. A partial write closes it, so its consumers must wait for writeback. A partial write completes in one cycle. At most four partial writes may be outstanding at once, and a fifth partial issue is refused.

The issue stage presents a destination register, a chunk mask and a partial flag. The block answers at once with an accept flag and a write-after-write flag. Writeback ports each return a register number, a chunk mask and a partial flag. A separate query port takes a reader's register and chunk mask. It reports whether any of those chunks is pending, whether the reader must stall, and whether it may take the value from the bypass instead.

Top module: `chunk_scoreboard`

## Requirements
- R1: After reset every busy flag is clear, so a query of any register with any mask reports q_pend=0, and the outstanding partial count is zero.
- R2: An accepted issue sets the busy flags of exactly the chunks selected by iss_mask (bit i selects bits 16i+15..16i of the register) in register iss_reg. It leaves every other chunk and register unchanged, and the change is visible to queries from the next cycle.
- R3: A writeback with wb_vld[p]=1 clears the busy flags of the chunks in wb_mask[16p+15:16p] of register wb_reg[6p+5:6p] from the next cycle. All writeback ports apply in the same cycle.
- R4: When an issue sets a chunk in the same cycle that a writeback clears it, the chunk ends busy, with the bypass permission of the new issue.
- R5: q_pend is 1 exactly when at least one chunk of q_reg selected by q_mask is busy. Busy chunks outside q_mask never affect the query.
- R6: q_fwd is 1 exactly when q_pend is 1 and every busy selected chunk was set by a full write (iss_part=0). q_stall is 1 exactly when some busy selected chunk was set by a partial write. The two are never both 1.
- R7: Chunks set by a partial write (iss_part=1) are never forwardable. A query touching such a chunk stalls until it is written back.
- R8: iss_waw is 1 exactly when iss_vld=1 and iss_mask overlaps a busy chunk of iss_reg. This holds whether or not the issue is accepted.
- R9: iss_acc is 0 exactly when iss_vld=1, iss_part=1 and four partial writes are outstanding. A refused issue changes no busy flag. Full writes are always accepted.
- R10: The outstanding partial count rises by one for each accepted partial issue and falls by one for each writeback port carrying wb_part=1 in the same cycle. Both changes apply together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| iss_vld | input | 1 | Issue request valid |
| iss_reg | input | 6 | Destination register of the issuing instruction |
| iss_mask | input | 16 | Destination chunks written, one bit per 16-bit slice |
| iss_part | input | 1 | Issuing instruction is a partial write (bypass barred) |
| iss_acc | output | 1 | Issue accepted and recorded |
| iss_waw | output | 1 | Issue overlaps busy chunks of its destination |
| wb_vld | input | 2 | Writeback valid, one bit per port |
| wb_reg | input | 12 | Writeback register numbers, 6 bits per port |
| wb_mask | input | 32 | Writeback chunk masks, 16 bits per port |
| wb_part | input | 2 | Writeback retires a partial write, one bit per port |
| q_reg | input | 6 | Register read by the candidate instruction |
| q_mask | input | 16 | Chunks read by the candidate instruction |
| q_pend | output | 1 | Some read chunk is still pending |
| q_stall | output | 1 | Reader must wait for writeback |
| q_fwd | output | 1 | All pending read chunks may come from the bypass |

## Verification
The assertions assume that writeback ports never retire more partial writes than are outstanding, counting a partial accepted in the same cycle. The partial counter and the refusal logic depend on that rule. The stimulus keeps to it by drawing the partial flags on the writeback ports only while a bench-side count of outstanding partials covers them. The assertions also assume that reset is released away from a clock edge. The bench drives reset and all inputs on the falling edge. Writeback masks and registers are otherwise left free, including masks that hit idle chunks and several ports that hit the same register.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int REG_W   = 256;
  localparam int CHUNK_W = 16;
  localparam int CHUNKS  = REG_W / CHUNK_W;
  typedef logic [CHUNKS-1:0] cmask_t;
endpackage

// File: rtl/csb_row.sv
module csb_row #(
  parameter int CHUNKS = 16,
  parameter int NWB    = 2,
  parameter int RIDX_W = 6,
  parameter int ROW    = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_en,
  input  logic [RIDX_W-1:0]       set_reg,
  input  logic [CHUNKS-1:0]       set_mask,
  input  logic                    set_part,
  input  logic [NWB-1:0]          wb_vld,
  input  logic [NWB*RIDX_W-1:0]   wb_reg,
  input  logic [NWB*CHUNKS-1:0]   wb_mask,
  output logic [CHUNKS-1:0]       busy_o,
  output logic [CHUNKS-1:0]       byp_o
);
  localparam logic [RIDX_W-1:0] MY_IDX = RIDX_W'(ROW);

  logic [CHUNKS-1:0] setv, clr, busy_q, busy_d, byp_q, byp_d;
  logic              row_en;

  // per-row decode of issue and all writeback ports
  always_comb begin
    setv = (set_en && set_reg == MY_IDX) ? set_mask : '0;
    clr  = '0;
    for (int p = 0; p < NWB; p++) begin
      if (wb_vld[p] && wb_reg[p*RIDX_W +: RIDX_W] == MY_IDX)
        clr = clr | wb_mask[p*CHUNKS +: CHUNKS];
    end
    busy_d = (busy_q & ~clr) | setv;                        // set wins
    byp_d  = (byp_q & ~setv) | (set_part ? '0 : setv);
    row_en = (|setv) || (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      byp_q  <= '0;
    end else if (row_en) begin
      busy_q <= busy_d;
      byp_q  <= byp_d;
    end
  end

  assign busy_o = busy_q;
  assign byp_o  = byp_q;

  // R2 / R4: chunks named by an accepted issue are busy next cycle
  a_r2_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (|setv) |=> ((busy_q & $past(setv)) == $past(setv)));
  // R3: cleared chunks with no concurrent set are idle next cycle
  a_r3_clear_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~setv)) |=> ((busy_q & $past(clr & ~setv)) == '0));
  // R7: partial producers never leave a forwardable chunk
  a_r7_partial_nobyp: assert property (@(posedge clk) disable iff (!rst_n)
    ((|setv) && set_part) |=> ((byp_q & $past(setv)) == '0));
  // R2: untouched chunks hold
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|setv) && !(|clr)) |=> $stable(busy_q));
endmodule

// File: rtl/csb_ptrack.sv
module csb_ptrack #(
  parameter int NWB      = 2,
  parameter int MAX_PART = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc,
  input  logic [NWB-1:0] wb_vld,
  input  logic [NWB-1:0] wb_part,
  output logic           full
);
  localparam int CNT_W = $clog2(MAX_PART + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  int               ndec;
  int               tmp;
  logic             cnt_en;

  always_comb begin
    ndec = 0;
    for (int p = 0; p < NWB; p++) begin
      if (wb_vld[p] && wb_part[p]) ndec = ndec + 1;
    end
    tmp    = int'(cnt_q) + (inc ? 1 : 0) - ndec;
    cnt_d  = tmp[CNT_W-1:0];
    cnt_en = inc || (ndec != 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign full = (cnt_q == CNT_W'(MAX_PART));

  // R9: never more than MAX_PART partial writes in flight
  a_r9_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_PART);
  // R10: retirements never exceed what is outstanding (input rule)
  a_r10_legal_retire: assert property (@(posedge clk) disable iff (!rst_n)
    ndec <= int'(cnt_q) + (inc ? 1 : 0));
  // R10: an issue with no retirement moves the count up by one
  a_r10_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && ndec == 0) |=> (int'(cnt_q) == int'($past(cnt_q)) + 1));
endmodule

// File: rtl/csb_query.sv
module csb_query #(
  parameter int NREGS  = 64,
  parameter int CHUNKS = 16,
  parameter int RIDX_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREGS-1:0][CHUNKS-1:0]  busy,
  input  logic [NREGS-1:0][CHUNKS-1:0]  byp,
  input  logic [RIDX_W-1:0]             q_reg,
  input  logic [CHUNKS-1:0]             q_mask,
  input  logic                          iss_vld,
  input  logic [RIDX_W-1:0]             iss_reg,
  input  logic [CHUNKS-1:0]             iss_mask,
  output logic                          q_pend,
  output logic                          q_stall,
  output logic                          q_fwd,
  output logic                          iss_waw
);
  logic [CHUNKS-1:0] pend_bits, hard_bits;

  always_comb begin
    pend_bits = busy[q_reg] & q_mask;
    hard_bits = pend_bits & ~byp[q_reg];
    q_pend    = |pend_bits;
    q_stall   = |hard_bits;
    q_fwd     = q_pend && !q_stall;
    iss_waw   = iss_vld && (|(busy[iss_reg] & iss_mask));
  end

  // R6: stall and forward are exclusive and both need a pending chunk
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_stall && q_fwd));
  a_r6_stall_pend: assert property (@(posedge clk) disable iff (!rst_n)
    q_stall |-> q_pend);
  // R5: an empty read mask is never pending
  a_r5_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (q_mask == '0) |-> !q_pend);
endmodule

// File: rtl/chunk_scoreboard.sv
module chunk_scoreboard #(
  parameter int NREGS    = 64,
  parameter int NWB      = 2,
  parameter int MAX_PART = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      iss_vld,
  input  logic [$clog2(NREGS)-1:0]                  iss_reg,
  input  logic [csb_pkg::CHUNKS-1:0]                iss_mask,
  input  logic                                      iss_part,
  output logic                                      iss_acc,
  output logic                                      iss_waw,
  input  logic [NWB-1:0]                            wb_vld,
  input  logic [NWB*$clog2(NREGS)-1:0]              wb_reg,
  input  logic [NWB*csb_pkg::CHUNKS-1:0]            wb_mask,
  input  logic [NWB-1:0]                            wb_part,
  input  logic [$clog2(NREGS)-1:0]                  q_reg,
  input  logic [csb_pkg::CHUNKS-1:0]                q_mask,
  output logic                                      q_pend,
  output logic                                      q_stall,
  output logic                                      q_fwd
);
  localparam int CHUNKS = csb_pkg::CHUNKS;
  localparam int RIDX_W = $clog2(NREGS);

  logic [NREGS-1:0][CHUNKS-1:0] busy, byp;
  logic                         part_full;

  assign iss_acc = iss_vld && !(iss_part && part_full);

  for (genvar r = 0; r < NREGS; r++) begin : g_row
    csb_row #(.CHUNKS(CHUNKS), .NWB(NWB), .RIDX_W(RIDX_W), .ROW(r)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (iss_acc),
      .set_reg  (iss_reg),
      .set_mask (iss_mask),
      .set_part (iss_part),
      .wb_vld   (wb_vld),
      .wb_reg   (wb_reg),
      .wb_mask  (wb_mask),
      .busy_o   (busy[r]),
      .byp_o    (byp[r])
    );
  end

  csb_ptrack #(.NWB(NWB), .MAX_PART(MAX_PART)) u_ptrack (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (iss_acc && iss_part),
    .wb_vld  (wb_vld),
    .wb_part (wb_part),
    .full    (part_full)
  );

  csb_query #(.NREGS(NREGS), .CHUNKS(CHUNKS), .RIDX_W(RIDX_W)) u_query (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .byp      (byp),
    .q_reg    (q_reg),
    .q_mask   (q_mask),
    .iss_vld  (iss_vld),
    .iss_reg  (iss_reg),
    .iss_mask (iss_mask),
    .q_pend   (q_pend),
    .q_stall  (q_stall),
    .q_fwd    (q_fwd),
    .iss_waw  (iss_waw)
  );

  // R9: full writes are never refused
  a_r9_full_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && !iss_part) |-> iss_acc);
  // R9: a refused issue leaves its destination unchanged
  a_r9_refused_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && !iss_acc && wb_vld == '0) |=> $stable(busy));
endmodule

// File: tb/sim_chunk_scoreboard.sv
`timescale 1ns/1ps
module sim_chunk_scoreboard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_vld, iss_part, iss_acc, iss_waw;
  logic [5:0]  iss_reg, q_reg;
  logic [15:0] iss_mask, q_mask;
  logic [1:0]  wb_vld, wb_part;
  logic [11:0] wb_reg;
  logic [31:0] wb_mask;
  logic        q_pend, q_stall, q_fwd;

  always #2.5 clk = ~clk;

  chunk_scoreboard u0 (
    .clk(clk), .rst_n(rst_n),
    .iss_vld(iss_vld), .iss_reg(iss_reg), .iss_mask(iss_mask), .iss_part(iss_part),
    .iss_acc(iss_acc), .iss_waw(iss_waw),
    .wb_vld(wb_vld), .wb_reg(wb_reg), .wb_mask(wb_mask), .wb_part(wb_part),
    .q_reg(q_reg), .q_mask(q_mask), .q_pend(q_pend), .q_stall(q_stall), .q_fwd(q_fwd)
  );

  logic [15:0] m_busy [64];
  logic [15:0] m_byp  [64];
  int          m_cnt;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational answers, update model at posedge
  task automatic cyc(input bit iv, input logic [5:0] ir, input logic [15:0] im, input bit ip,
                     input logic [1:0] wv, input logic [5:0] wr0, input logic [15:0] wm0,
                     input bit wp0, input logic [5:0] wr1, input logic [15:0] wm1, input bit wp1,
                     input logic [5:0] qr, input logic [15:0] qm);
    logic [15:0] pb, hb, clr0, clr1;
    bit acc;
    @(negedge clk);
    iss_vld = iv; iss_reg = ir; iss_mask = im; iss_part = ip;
    wb_vld = wv; wb_reg = {wr1, wr0}; wb_mask = {wm1, wm0}; wb_part = {wp1, wp0};
    q_reg = qr; q_mask = qm;
    #1;
    pb  = m_busy[qr] & qm;
    hb  = pb & ~m_byp[qr];
    acc = iv && !(ip && m_cnt >= 4);
    chk("R5 q_pend", int'(q_pend), int'(|pb));
    chk("R6 R7 q_stall", int'(q_stall), int'(|hb));
    chk("R6 q_fwd", int'(q_fwd), int'((|pb) && !(|hb)));
    chk("R9 iss_acc", int'(iss_acc), int'(acc));
    chk("R8 iss_waw", int'(iss_waw), int'(iv && (|(m_busy[ir] & im))));
    @(posedge clk);
    for (int r = 0; r < 64; r++) begin
      clr0 = (wv[0] && wr0 == r[5:0]) ? wm0 : 16'h0;
      clr1 = (wv[1] && wr1 == r[5:0]) ? wm1 : 16'h0;
      m_busy[r] = m_busy[r] & ~(clr0 | clr1);
      if (acc && ir == r[5:0]) begin
        m_busy[r] = m_busy[r] | im;
        m_byp[r]  = ip ? (m_byp[r] & ~im) : (m_byp[r] | im);
      end
    end
    m_cnt = m_cnt + ((acc && ip) ? 1 : 0) - ((wv[0] && wp0) ? 1 : 0) - ((wv[1] && wp1) ? 1 : 0);
  endtask

  task automatic idle_q(input logic [5:0] qr, input logic [15:0] qm);
    cyc(0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, qr, qm);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    iss_vld = 0; iss_reg = 0; iss_mask = 0; iss_part = 0;
    wb_vld = 0; wb_reg = 0; wb_mask = 0; wb_part = 0; q_reg = 0; q_mask = 0;
    for (int r = 0; r < 64; r++) begin m_busy[r] = 16'h0; m_byp[r] = 16'h0; end
    m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every register idle after reset
    for (int r = 0; r < 64; r++) idle_q(r[5:0], 16'hFFFF);

    // R2 R5: full write to chunks 4..7 of reg 3; chunk 0 not a false dependency
    cyc(1, 6'd3, 16'h00F0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 6'd3, 16'h0001);
    idle_q(6'd3, 16'h0001);
    idle_q(6'd3, 16'h0010);          // R6 forwardable
    idle_q(6'd4, 16'hFFFF);          // R2 other register untouched
    // R4: partial sets chunk 4 while writeback clears 4..7
    cyc(1, 6'd3, 16'h0010, 1, 2'b01, 6'd3, 16'h00F0, 0, 0, 0, 0, 6'd3, 16'h00F0);
    idle_q(6'd3, 16'h00E0);          // R3 cleared chunks
    idle_q(6'd3, 16'h0010);          // R4 R7 stall
    cyc(0, 0, 0, 0, 2'b01, 6'd3, 16'h0010, 1, 0, 0, 0, 6'd3, 16'h0010);
    idle_q(6'd3, 16'hFFFF);

    // R9: four partials outstanding, fifth refused, full still accepted
    for (int k = 0; k < 4; k++)
      cyc(1, 6'(10 + k), 16'h0001, 1, 2'b00, 0, 0, 0, 0, 0, 0, 6'd10, 16'h0001);
    cyc(1, 6'd20, 16'h0100, 1, 2'b00, 0, 0, 0, 0, 0, 0, 6'd20, 16'hFFFF);
    idle_q(6'd20, 16'hFFFF);         // R9 refused issue left no mark
    cyc(1, 6'd21, 16'hFFFF, 0, 2'b00, 0, 0, 0, 0, 0, 0, 6'd21, 16'hFFFF);
    // R10: two partial retirements on both ports in one cycle
    cyc(0, 0, 0, 0, 2'b11, 6'd10, 16'h0001, 1, 6'd11, 16'h0001, 1, 6'd10, 16'h0001);
    cyc(1, 6'd22, 16'h0002, 1, 2'b00, 0, 0, 0, 0, 0, 0, 6'd11, 16'h0001);
    cyc(1, 6'd23, 16'h0002, 1, 2'b00, 0, 0, 0, 0, 0, 0, 6'd22, 16'h0002);
    cyc(1, 6'd24, 16'h0002, 1, 2'b00, 0, 0, 0, 0, 0, 0, 6'd24, 16'h0002);

    // near-exhaustive sweep over a small register window
    for (int n = 0; n < 6000; n++) begin
      logic [5:0] ir, qr, wr0, wr1;
      logic [15:0] im, qm, wm0, wm1;
      bit iv, ip, wp0, wp1;
      logic [1:0] wv;
      int room;
      iv  = ($urandom % 3) != 0;
      ip  = ($urandom % 3) == 0;
      ir  = 6'($urandom % 8) + ((n % 97 == 0) ? 6'd50 : 6'd0);
      im  = 16'($urandom);
      if ($urandom % 2) im = 16'h1 << ($urandom % 16);
      wv  = 2'($urandom);
      wr0 = 6'($urandom % 8);
      wr1 = 6'($urandom % 8);
      wm0 = ($urandom % 4 == 0) ? 16'($urandom) : (m_busy[wr0] & 16'($urandom));
      wm1 = ($urandom % 4 == 0) ? 16'($urandom) : (m_busy[wr1] & 16'($urandom));
      room = m_cnt;
      wp0 = wv[0] && room > 0 && ($urandom % 2);
      if (wp0) room--;
      wp1 = wv[1] && room > 0 && ($urandom % 2);
      qr  = 6'($urandom % 8);
      qm  = ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom);
      cyc(iv, ir, im, ip, wv, wr0, wm0, wp0, wr1, wm1, wp1, qr, qm);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule